// File: doc/BRIEF.md
# Punctured Rate-1/2 Convolutional Encoder

This block turns a stream of information bits into a serial stream of coded bits. It uses a constraint-length-7 shift-register code with generators 133 and 171 (octal). The code is non-systematic: for every accepted information bit the two generator parities are formed, and the information bit itself is never sent.

A puncturing stage, selected at run time, can drop some of these parities. This lifts the code rate from 1/2 to 2/3 or 3/4. A flush request feeds six zero bits through the register, so each block ends in the all-zero state. A start pulse begins a new block with a cleared register and the puncture column at zero.

The output is a one-bit stream with a valid/ready handshake. When the output stalls, the input ready signal drops, so no bit is ever lost.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, coded_valid_o is 0, data_ready_o is 1, and the register holds the zero state.
- R2: With rate_i = 0, each accepted bit yields two output bits: first the 133 parity, then the 171 parity. Each parity is the XOR of the window bits selected by its generator. Window bit 6 is the current input, bit 5 is the input one step earlier, and so on down to bit 0, the input six steps earlier. Generator bit 6 is its most significant octal bit.
- R3: With rate_i = 1 the puncture period is two columns. Column 0 keeps both parities. Column 1 keeps only the 133 parity.
- R4: With rate_i = 2 the puncture period is three columns. Column 0 keeps both parities, column 1 keeps only the 133 parity, and column 2 keeps only the 171 parity. rate_i = 3 behaves like rate_i = 0. The column advances once per shifted bit.
- R5: A one-cycle flush_i pulse shifts six zero bits through the register, and the active pattern punctures them. data_ready_o is 0 from the cycle after the pulse until the six shifts are done. Afterwards the register is zero, and the puncture column carries on from where it stood.
- R6: A start_i pulse clears the register, the puncture column and any tail in progress. No bit is accepted in that cycle.
- R7: While coded_valid_o is 1 and coded_ready_i is 0, coded_valid_o and coded_o hold their values. Every generated bit is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block |
| flush_i | input | 1 | Request the six-bit zero tail |
| rate_i | input | 2 | 0: 1/2, 1: 2/3, 2: 3/4, 3: 1/2 |
| data_i | input | 1 | Information bit |
| data_valid_i | input | 1 | data_i is valid |
| data_ready_o | output | 1 | Encoder accepts data_i this cycle |
| coded_o | output | 1 | Coded bit |
| coded_valid_o | output | 1 | coded_o is valid |
| coded_ready_i | input | 1 | Downstream accepts coded_o |

## Verification
A bit accepted at a clock edge gives its first kept parity on coded_o right after that edge. A second kept parity follows one edge after the first has been taken. A flush pulse lowers data_ready_o right after the edge that samples it. A start pulse clears the state at the edge that samples it. The bench drives inputs at the falling edge, evaluates both handshakes 1 ns later, and records an output bit only when valid and ready were both high ahead of the coming rising edge. It then compares the whole recorded stream of each block with a software model of the code, so the result does not depend on exactly when stalls make each bit come out.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CONSTR_LEN = 7;
  localparam logic [CONSTR_LEN-1:0] GEN_A = 7'o133;
  localparam logic [CONSTR_LEN-1:0] GEN_B = 7'o171;

  // {keep 133 parity, keep 171 parity}
  function automatic logic [1:0] keep_mask(input logic [1:0] rate, input logic [1:0] col);
    logic [1:0] m;
    case (rate)
      2'd1: m = (col == 2'd0) ? 2'b11 : 2'b10;
      2'd2: begin
        case (col)
          2'd0: m = 2'b11;
          2'd1: m = 2'b10;
          default: m = 2'b01;
        endcase
      end
      default: m = 2'b11;
    endcase
    return m;
  endfunction

  function automatic logic [1:0] col_count(input logic [1:0] rate);
    logic [1:0] c;
    case (rate)
      2'd1: c = 2'd2;
      2'd2: c = 2'd3;
      default: c = 2'd1;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/conv_core.sv
module conv_core #(
  parameter int unsigned K = 7,
  parameter logic [K-1:0] G1 = 7'o133,
  parameter logic [K-1:0] G2 = 7'o171,
  localparam int unsigned MEM = K - 1,
  localparam int unsigned TW = $clog2(MEM + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           shift_i,
  input  logic           flush_i,
  input  logic           data_i,
  output logic [1:0]     code_o,
  output logic           tail_o,
  output logic [MEM-1:0] state_o
);
  logic [MEM-1:0] hist_q;
  logic [TW-1:0]  tail_cnt_q;
  logic           in_bit;
  logic [K-1:0]   win;

  assign tail_o  = (tail_cnt_q != '0);
  assign in_bit  = tail_o ? 1'b0 : data_i;
  assign win     = {in_bit, hist_q};
  assign code_o  = {^(win & G1), ^(win & G2)};
  assign state_o = hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q     <= '0;
      tail_cnt_q <= '0;
    end else if (clear_i) begin
      hist_q     <= '0;
      tail_cnt_q <= '0;
    end else begin
      if (shift_i) hist_q <= {in_bit, hist_q[MEM-1:1]};
      if (tail_o && shift_i) tail_cnt_q <= tail_cnt_q - 1'b1;
      else if (flush_i && !tail_o) tail_cnt_q <= TW'(MEM);
    end
  end
endmodule

// File: rtl/punct_ctrl.sv
module punct_ctrl
  import conv_enc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  input  logic [1:0] rate_i,
  output logic [1:0] keep_o
);
  logic [1:0] col_q;
  logic       wrap;

  // wrap also covers a column left out of range by a rate change
  assign wrap   = ({1'b0, col_q} + 3'd1) >= {1'b0, col_count(rate_i)};
  assign keep_o = keep_mask(rate_i, col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      col_q <= '0;
    else if (clear_i) col_q <= '0;
    else if (step_i)  col_q <= wrap ? 2'd0 : col_q + 2'd1;
  end
endmodule

// File: rtl/bit_serializer.sv
module bit_serializer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] code_i,
  input  logic [1:0] keep_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic       bit_o,
  output logic       free_o
);
  logic [1:0] cnt_q;
  logic [1:0] buf_q;
  logic       fire;

  assign valid_o = (cnt_q != 2'd0);
  assign bit_o   = buf_q[1];
  assign fire    = valid_o && ready_i;
  assign free_o  = (cnt_q == 2'd0) || ((cnt_q == 2'd1) && fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (load_i) begin
      case (keep_i)
        2'b11:   begin buf_q <= code_i;          cnt_q <= 2'd2; end
        2'b10:   begin buf_q <= {code_i[1], 1'b0}; cnt_q <= 2'd1; end
        2'b01:   begin buf_q <= {code_i[0], 1'b0}; cnt_q <= 2'd1; end
        default: begin buf_q <= '0;              cnt_q <= 2'd0; end
      endcase
    end else if (fire) begin
      buf_q <= {buf_q[0], 1'b0};
      cnt_q <= cnt_q - 2'd1;
    end
  end
endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
  import conv_enc_pkg::*;
#(
  parameter int unsigned K = CONSTR_LEN,
  parameter logic [K-1:0] G1 = GEN_A,
  parameter logic [K-1:0] G2 = GEN_B,
  localparam int unsigned MEM = K - 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       flush_i,
  input  logic [1:0] rate_i,
  input  logic       data_i,
  input  logic       data_valid_i,
  output logic       data_ready_o,
  output logic       coded_o,
  output logic       coded_valid_o,
  input  logic       coded_ready_i
);
  logic           tail_act;
  logic           slot_free;
  logic           shift;
  logic [1:0]     code;
  logic [1:0]     keep;
  logic [MEM-1:0] state_q;

  assign shift        = slot_free && !start_i && (tail_act || data_valid_i);
  assign data_ready_o = slot_free && !start_i && !tail_act;

  conv_core #(.K(K), .G1(G1), .G2(G2)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .shift_i (shift),
    .flush_i (flush_i),
    .data_i  (data_i),
    .code_o  (code),
    .tail_o  (tail_act),
    .state_o (state_q)
  );

  punct_ctrl u_punct (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .step_i  (shift),
    .rate_i  (rate_i),
    .keep_o  (keep)
  );

  bit_serializer u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (shift),
    .code_i  (code),
    .keep_i  (keep),
    .ready_i (coded_ready_i),
    .valid_o (coded_valid_o),
    .bit_o   (coded_o),
    .free_o  (slot_free)
  );
endmodule

// File: rtl/conv_punct_enc_chk.sv
module conv_punct_enc_chk #(
  parameter int unsigned MEM = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           coded_valid_o,
  input logic           coded_ready_i,
  input logic           coded_o,
  input logic           tail_act,
  input logic [MEM-1:0] state_q,
  input logic [1:0]     keep,
  input logic           shift
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coded_valid_o && !coded_ready_i |=> coded_valid_o && $stable(coded_o));

  // R5
  tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tail_act) |-> state_q == '0);

  // R6
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_q == '0 && !tail_act);

  // R4
  keep_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift |-> keep != 2'b00);
endmodule

bind conv_punct_enc conv_punct_enc_chk #(.MEM(K - 1)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .coded_valid_o (coded_valid_o),
  .coded_ready_i (coded_ready_i),
  .coded_o       (coded_o),
  .tail_act      (tail_act),
  .state_q       (state_q),
  .keep          (keep),
  .shift         (shift)
);

// File: tb/tb_conv_punct_enc.sv
module tb_conv_punct_enc;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       flush_i = 1'b0;
  logic [1:0] rate_i = 2'd0;
  logic       data_i = 1'b0;
  logic       data_valid_i = 1'b0;
  logic       data_ready_o;
  logic       coded_o;
  logic       coded_valid_o;
  logic       coded_ready_i = 1'b1;

  always #2.5 clk = ~clk;

  conv_punct_enc dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .flush_i(flush_i),
    .rate_i(rate_i), .data_i(data_i), .data_valid_i(data_valid_i),
    .data_ready_o(data_ready_o), .coded_o(coded_o),
    .coded_valid_o(coded_valid_o), .coded_ready_i(coded_ready_i)
  );

  typedef struct packed {
    logic [1:0]  rate;
    logic [5:0]  n;
    logic [31:0] bits;
    logic        start;
    logic        flush;
    logic        stall;
    logic [3:0]  req;
  } vec_t;

  // R2 plain; R3 and R4 punctured; R5 continue after tail; R6 start over dirty state; R7 stalls
  localparam vec_t VEC [7] = '{
    '{2'd0, 6'd16, 32'hB5E31A6C, 1'b1, 1'b1, 1'b0, 4'd2},
    '{2'd1, 6'd12, 32'h00000F5A, 1'b1, 1'b1, 1'b1, 4'd3},
    '{2'd2, 6'd18, 32'h0002C6B9, 1'b1, 1'b1, 1'b0, 4'd4},
    '{2'd2, 6'd9,  32'h000001B3, 1'b0, 1'b0, 1'b1, 4'd5},
    '{2'd1, 6'd10, 32'h000002D5, 1'b1, 1'b1, 1'b0, 4'd6},
    '{2'd3, 6'd8,  32'h000000A7, 1'b1, 1'b1, 1'b1, 4'd4},
    '{2'd0, 6'd20, 32'h000FFFFF, 1'b0, 1'b1, 1'b1, 4'd7}
  };

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit got [256];
  bit exp_b [256];
  int ng, ne;
  logic [5:0] m_hist;
  int m_col;
  bit stall_mode;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit par(input logic [6:0] v);
    return ^v;
  endfunction

  task automatic model_bit(input bit b, input logic [1:0] rate);
    logic [6:0] w;
    bit k1, k2;
    int per;
    w = {b, m_hist};
    per = (rate == 2'd1) ? 2 : (rate == 2'd2) ? 3 : 1;
    k1 = 1'b1; k2 = 1'b1;
    if (rate == 2'd1 && m_col == 1) k2 = 1'b0;
    if (rate == 2'd2 && m_col == 1) k2 = 1'b0;
    if (rate == 2'd2 && m_col == 2) k1 = 1'b0;
    if (k1) begin exp_b[ne] = par(w & 7'b1011011); ne++; end
    if (k2) begin exp_b[ne] = par(w & 7'b1111001); ne++; end
    m_hist = {b, m_hist[5:1]};
    m_col = (m_col + 1 >= per) ? 0 : m_col + 1;
  endtask

  // inputs are set before the call; handshakes evaluated ahead of the next rising edge
  task automatic step(output bit acc);
    if (stall_mode) coded_ready_i = (cyc % 3 != 1);
    #1;
    if (coded_valid_o && coded_ready_i) begin got[ng] = coded_o; ng++; end
    acc = data_valid_i && data_ready_o;
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    bit a;
    for (int t = 0; t < 400 && (ng < ne || coded_valid_o); t++) step(a);
  endtask

  task automatic cmp_stream(input string req);
    int bad;
    bad = -1;
    chk(ng == ne, {req, " length"}, ng, ne);
    for (int i = 0; i < ne && i < ng; i++) if (bad < 0 && got[i] != exp_b[i]) bad = i;
    chk(bad < 0, $sformatf("%s stream bit %0d", req, bad), (bad < 0) ? 0 : int'(got[bad]),
        (bad < 0) ? 0 : int'(exp_b[bad]));
  endtask

  task automatic run_vec(input vec_t v);
    bit a;
    ng = 0; ne = 0;
    stall_mode = v.stall;
    coded_ready_i = 1'b1;
    rate_i = v.rate;
    if (v.start) begin
      start_i = 1'b1; step(a); start_i = 1'b0;
      m_hist = '0; m_col = 0;
    end
    for (int i = 0; i < int'(v.n); i++) begin
      data_i = v.bits[i]; data_valid_i = 1'b1;
      a = 1'b0;
      while (!a) step(a);
      model_bit(v.bits[i], v.rate);
    end
    data_valid_i = 1'b0;
    if (v.flush) begin
      flush_i = 1'b1; step(a); flush_i = 1'b0;
      for (int i = 0; i < 6; i++) model_bit(1'b0, v.rate);
    end
    drain();
    stall_mode = 1'b0;
    coded_ready_i = 1'b1;
    cmp_stream($sformatf("R%0d", v.req));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual %0d expected 0", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    bit a;
    int held_bad, waited;
    m_hist = '0; m_col = 0; stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1
    chk(coded_valid_o == 1'b0, "R1 valid after reset", coded_valid_o, 0);
    chk(data_ready_o == 1'b1, "R1 ready after reset", data_ready_o, 1);
    @(negedge clk);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R7: single bit 1 from zero state gives parities 1,1; hold under stall
    ng = 0; ne = 0; rate_i = 2'd0; coded_ready_i = 1'b0;
    start_i = 1'b1; step(a); start_i = 1'b0;
    data_i = 1'b1; data_valid_i = 1'b1;
    a = 1'b0;
    while (!a) step(a);
    data_valid_i = 1'b0;
    held_bad = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (!(coded_valid_o && coded_o == 1'b1)) held_bad++;
      @(negedge clk); cyc++;
    end
    chk(held_bad == 0, "R7 hold under stall", held_bad, 0);
    coded_ready_i = 1'b1;
    exp_b[0] = 1'b1; exp_b[1] = 1'b1; ne = 2;
    drain();
    cmp_stream("R7");

    // R5: tail blocks input; 12 zero bits then bit 1 from zero state
    ng = 0; ne = 0; rate_i = 2'd0;
    start_i = 1'b1; step(a); start_i = 1'b0;
    flush_i = 1'b1; step(a); flush_i = 1'b0;
    #0.5;
    chk(data_ready_o == 1'b0, "R5 ready low in tail", data_ready_o, 0);
    data_i = 1'b1; data_valid_i = 1'b1;
    a = 1'b0; waited = 0;
    while (!a) begin step(a); waited++; end
    data_valid_i = 1'b0;
    chk(waited >= 7, "R5 tail steps before data", waited, 7);
    for (int i = 0; i < 12; i++) exp_b[i] = 1'b0;
    exp_b[12] = 1'b1; exp_b[13] = 1'b1; ne = 14;
    drain();
    cmp_stream("R5");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule